// File: doc/BRIEF.md
# Two-Tone FSK Bit Detector

This block recovers the bit level carried by a frequency-shift-keyed line from a stream of signed converter samples. Each sample that arrives with its valid strobe is written into a twelve-slot ring. Two quadrature correlators then run over the whole ring. One is matched to the low ("0") tone, which completes one cycle per twelve samples. The other is matched to the high ("1") tone, which completes two cycles per twelve samples.

Each correlator forms an in-phase and a quadrature sum. It reduces them to a magnitude estimate |I|+|Q|. A decision stage compares the two magnitudes against a programmable margin and holds its previous level while the two tones are too close to call. A downstream byte framer samples `bit_out` whenever `bit_valid` is high.

After reset the line reads idle ("1") until twelve samples have been accepted. From then on every accepted sample yields a fresh decision two clock edges later.

Top module: `fsk_tone_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state: `bit_out` becomes 1, `bit_valid` becomes 0, and the next accepted sample goes to ring slot 0.
- R2: A sample is accepted only on an edge where `smp_vld` is 1. It is written to the current slot, and the slot index then advances 0,1,...,11,0. While `smp_vld` is 0, `smp_data` has no effect on any later output.
- R3: The zero-tone magnitude is |I0|+|Q0|, where I0 = sum over slots s of x[s]*C(s mod 12) and Q0 = sum of x[s]*C((s+3) mod 12). The table C(n) = round(64*sin(2*pi*n/12)) has the values 0,32,55,64,55,32,0,-32,-55,-64,-55,-32, and x is the signed two's-complement slot content.
- R4: The one-tone magnitude is |I1|+|Q1|, formed with the same table at indices (2s mod 12) for I1 and (2s+3 mod 12) for Q1.
- R5: Once the ring is full, each accepted sample sets `bit_out` to 1 if the one-tone magnitude exceeds the zero-tone magnitude plus `hyst_margin` (strictly). It sets `bit_out` to 0 if the zero-tone magnitude exceeds the one-tone magnitude plus `hyst_margin`. Otherwise `bit_out` keeps its value.
- R6: `bit_valid` rises with the decision for the twelfth sample accepted since reset and stays at 1 until the next reset.
- R7: Until `bit_valid` is 1, `bit_out` stays 1 whatever samples arrive.
- R8: For a sample accepted at edge E, `bit_out` and `bit_valid` still show the earlier state after edge E+1 and show the new decision after edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample strobe, one accepted sample per high edge |
| smp_data | input | SAMPLE_W | Signed converter sample |
| hyst_margin | input | HYST_W | Unsigned margin one magnitude must exceed the other by |
| bit_out | output | 1 | Decided line level, 1 when idle |
| bit_valid | output | 1 | High once the ring has filled after reset |

## Verification
The bench attacks the fill boundary. A detector that validated on the eleventh sample, or that let a strong zero tone through before the ring was full, would drop `bit_out` early. A slot pointer that failed to wrap after slot 11, or that did not restart at slot 0 after a mid-run reset, would pair samples with the wrong coefficients, and its magnitudes would stop matching the bench's arithmetic model in the long runs.

Mixtures of both tones are fed against a sweep of margins up to the full margin range, which pins down the strict-greater comparison and the hold band. With a large margin, a design that compared without the margin would flip. Full-scale positive and negative samples check that the sums do not wrap. Every sample is checked one edge too early and at the right edge, so an extra or a missing pipeline register shows up.

// File: rtl/fsk_det_pkg.sv
// Package fsk_det_pkg
// Shared constants and the quadrature coefficient table for the two-tone
// detector. The table holds one full period of a sine scaled by 64 over the
// ring length, built by folding a quarter wave so that no long list is stored.
package fsk_det_pkg;

    localparam int WIN    = 12;  // ring length, one period of the low tone
    localparam int COEF_W = 8;   // signed coefficient width

    // Quarter-wave values for indices 0..3 of round(64*sin(2*pi*n/12)).
    function automatic int quarter_wave(input int n);
        case (n)
            0:       return 0;
            1:       return 32;
            2:       return 55;
            default: return 64;
        endcase
    endfunction

    // Full-period signed coefficient for any non-negative index.
    function automatic logic signed [COEF_W-1:0] sine_q(input int idx);
        int i;
        int v;
        i = idx % WIN;
        if (i <= 3)
            v = quarter_wave(i);
        else if (i <= 6)
            v = quarter_wave(6 - i);
        else if (i <= 9)
            v = -quarter_wave(i - 6);
        else
            v = -quarter_wave(12 - i);
        return COEF_W'(v);
    endfunction

endpackage

// File: rtl/fsk_sample_ring.sv
// Module fsk_sample_ring
// Circular sample store for the correlators. Every strobed sample lands in
// the slot named by a write pointer that wraps modulo DEPTH. A saturating fill
// counter reports when every slot has been written since reset.
// Assumes: synchronous active-low reset; all slots exposed in parallel.
module fsk_sample_ring #(
    parameter int SAMPLE_W = 8,
    parameter int DEPTH    = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SAMPLE_W-1:0]                wr_data,
    output logic [DEPTH-1:0][SAMPLE_W-1:0]     taps,
    output logic                               full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wptr;
    logic [CNT_W-1:0] fill;

    assign full = (fill == CNT_W'(DEPTH));

    // Write the slot, advance the pointer with wrap, count fill up to DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
            wptr <= '0;
            fill <= '0;
        end else if (wr_en) begin
            taps[wptr] <= wr_data;
            wptr       <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + PTR_W'(1);
            if (!full)
                fill <= fill + CNT_W'(1);
        end
    end

    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wptr < PTR_W'(DEPTH));

    a_r2_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wptr == PTR_W'(DEPTH - 1)) |=> (wptr == '0));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(wptr) && $stable(taps)));

    a_r6_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);

endmodule

// File: rtl/fsk_tone_corr.sv
// Module fsk_tone_corr
// Quadrature correlator for one tone. Slot s of the ring is weighted by the
// table entry at (CYCLES*s) for the in-phase sum and (CYCLES*s+3) for the
// quadrature sum, a quarter period later. The registered output is |I|+|Q|.
// Assumes: ring length equals the table period; en marks a fresh ring.
module fsk_tone_corr
    import fsk_det_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int CYCLES   = 1,
    parameter int MAG_W    = 22
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en,
    input  logic [WIN-1:0][SAMPLE_W-1:0]   taps,
    output logic [MAG_W-1:0]               mag
);

    localparam int ACC_W = MAG_W - 1;

    logic signed [ACC_W-1:0] acc_i;
    logic signed [ACC_W-1:0] acc_q;
    logic        [ACC_W-1:0] abs_i;
    logic        [ACC_W-1:0] abs_q;

    // Multiply-accumulate every slot against both coefficient phases.
    always_comb begin
        acc_i = '0;
        acc_q = '0;
        for (int s = 0; s < WIN; s++) begin
            acc_i = acc_i + ACC_W'($signed(taps[s])) * ACC_W'(sine_q(CYCLES * s));
            acc_q = acc_q + ACC_W'($signed(taps[s])) * ACC_W'(sine_q(CYCLES * s + 3));
        end
    end

    // Absolute values of both sums.
    always_comb begin
        abs_i = acc_i[ACC_W-1] ? ACC_W'(-acc_i) : ACC_W'(acc_i);
        abs_q = acc_q[ACC_W-1] ? ACC_W'(-acc_q) : ACC_W'(acc_q);
    end

    // Register the magnitude estimate when a new ring state is presented.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mag <= '0;
        else if (en)
            mag <= MAG_W'(abs_i) + MAG_W'(abs_q);
    end

    a_r3_mag_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(mag));

    a_r4_mag_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        mag <= MAG_W'(2 * WIN * 64 * (1 << (SAMPLE_W - 1))));

endmodule

// File: rtl/fsk_bit_decide.sv
// Module fsk_bit_decide
// Hysteretic comparison of the two tone magnitudes. A side wins only when it
// beats the other by more than the margin; otherwise the level is held.
// Decisions start once the ring is full, which also raises the valid flag.
// Assumes: dec_en arrives together with the magnitudes it refers to.
module fsk_bit_decide #(
    parameter int MAG_W  = 22,
    parameter int HYST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic              ring_full,
    input  logic [MAG_W-1:0]  mag_zero,
    input  logic [MAG_W-1:0]  mag_one,
    input  logic [HYST_W-1:0] hyst,
    output logic              bit_out,
    output logic              bit_valid
);

    localparam int CMP_W = ((MAG_W > HYST_W) ? MAG_W : HYST_W) + 1;

    logic one_wins;
    logic zero_wins;

    // Margin comparisons, widened so the sum cannot wrap.
    always_comb begin
        one_wins  = CMP_W'(mag_one)  > (CMP_W'(mag_zero) + CMP_W'(hyst));
        zero_wins = CMP_W'(mag_zero) > (CMP_W'(mag_one)  + CMP_W'(hyst));
    end

    // Update level and valid flag on each decision once the ring is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b1;
            bit_valid <= 1'b0;
        end else if (dec_en && ring_full) begin
            bit_valid <= 1'b1;
            if (one_wins)
                bit_out <= 1'b1;
            else if (zero_wins)
                bit_out <= 1'b0;
        end
    end

    a_r7_idle_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> bit_out);

    a_r6_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> bit_valid);

    a_r8_no_update_without_decision: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> ($stable(bit_out) && $stable(bit_valid)));

    a_r5_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && (({1'b0, mag_one} <= {1'b0, mag_zero} + hyst) &&
                    ({1'b0, mag_zero} <= {1'b0, mag_one} + hyst)))
        |=> $stable(bit_out));

endmodule

// File: rtl/fsk_tone_detector.sv
// Module fsk_tone_detector
// Top of the two-tone bit detector. A strobed sample is written to the ring
// (edge E). Both correlators register their magnitudes from the updated ring
// (edge E+1), and the decision stage updates the bit (edge E+2). The ring-full
// flag is delayed one cycle so that it matches the magnitudes it gates.
// Assumes: samples are signed two's complement; reset is synchronous, active low.
module fsk_tone_detector
    import fsk_det_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int HYST_W   = 16,
    parameter int ZERO_CYC = 1,
    parameter int ONE_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [HYST_W-1:0]   hyst_margin,
    output logic                bit_out,
    output logic                bit_valid
);

    localparam int MAG_W = SAMPLE_W + COEF_W + $clog2(WIN) + 2;

    logic [WIN-1:0][SAMPLE_W-1:0] taps;
    logic                         ring_full;
    logic                         full_d;
    logic                         corr_en;
    logic                         dec_en;
    logic [1:0][MAG_W-1:0]        mags;

    fsk_sample_ring #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (WIN)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (smp_vld),
        .wr_data (smp_data),
        .taps    (taps),
        .full    (ring_full)
    );

    // Stage strobes and the delayed full flag that follow each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_en <= 1'b0;
            dec_en  <= 1'b0;
            full_d  <= 1'b0;
        end else begin
            corr_en <= smp_vld;
            dec_en  <= corr_en;
            full_d  <= ring_full;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_tone
        localparam int CYC = (g == 0) ? ZERO_CYC : ONE_CYC;
        fsk_tone_corr #(
            .SAMPLE_W (SAMPLE_W),
            .CYCLES   (CYC),
            .MAG_W    (MAG_W)
        ) u_corr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (corr_en),
            .taps  (taps),
            .mag   (mags[g])
        );
    end

    fsk_bit_decide #(
        .MAG_W  (MAG_W),
        .HYST_W (HYST_W)
    ) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_en    (dec_en),
        .ring_full (full_d),
        .mag_zero  (mags[0]),
        .mag_one   (mags[1]),
        .hyst      (hyst_margin),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    a_r8_decision_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> $past(smp_vld, 2));

    a_r6_valid_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_valid) |-> full_d);

endmodule

// File: tb/test_fsk_tone_detector.sv
// Bench for fsk_tone_detector. The bench keeps its own arithmetic model of the
// ring, the two correlators and the hysteretic decision. It sweeps tones,
// mixtures, noise and full-scale values over several margins, and checks
// every sample one edge early and at its decision edge.
module test_fsk_tone_detector;

    localparam int SW = 8;
    localparam int HW = 16;
    localparam real PI = 3.14159265358979;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          smp_vld;
    logic [SW-1:0] smp_data;
    logic [HW-1:0] hyst;
    logic          bit_out;
    logic          bit_valid;

    int n_chk = 0;
    int n_fail = 0;
    int mbuf[12];
    int mwp;
    int mcnt;
    logic mbit;
    logic mvld;
    int ph = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    fsk_tone_detector #(.SAMPLE_W(SW), .HYST_W(HW)) i_fsk_tone_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_data    (smp_data),
        .hyst_margin (hyst),
        .bit_out     (bit_out),
        .bit_valid   (bit_valid)
    );

    // Coefficient from the stated formula round(64*sin(2*pi*n/12)).
    function automatic int coef(input int n);
        return int'(64.0 * $sin(2.0 * PI * real'(n % 12) / 12.0));
    endfunction

    // Magnitude |I|+|Q| of the model ring for a tone of k cycles per ring.
    function automatic int tone_mag(input int k);
        int si = 0;
        int sq = 0;
        for (int s = 0; s < 12; s++) begin
            si += mbuf[s] * coef(k * s);
            sq += mbuf[s] * coef(k * s + 3);
        end
        if (si < 0) si = -si;
        if (sq < 0) sq = -sq;
        return si + sq;
    endfunction

    function automatic int clamp(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 12; s++) mbuf[s] = 0;
        mwp = 0;
        mcnt = 0;
        mbit = 1'b1;
        mvld = 1'b0;
    endtask

    function automatic logic [15:0] step_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Drive one sample and check both the early edge and the decision edge.
    task automatic send(input int s);
        int m0;
        int m1;
        string req;
        smp_vld  = 1'b1;
        smp_data = SW'(s);
        @(negedge clk);
        smp_vld  = 1'b0;
        lfsr     = step_lfsr(lfsr);
        smp_data = lfsr[SW-1:0];          // R2: garbage while strobe is low
        @(negedge clk);
        chk(bit_out,   mbit, "R8", "bit one edge after sample");
        chk(bit_valid, mvld, "R8", "valid one edge after sample");
        mbuf[mwp] = s;
        mwp = (mwp + 1) % 12;
        if (mcnt < 12) mcnt++;
        req = "R5 (R3,R4 magnitudes)";
        if (mcnt == 12) begin
            m0 = tone_mag(1);
            m1 = tone_mag(2);
            if (!mvld) req = "R6";
            mvld = 1'b1;
            if (m1 > m0 + int'(hyst)) mbit = 1'b1;
            else if (m0 > m1 + int'(hyst)) mbit = 1'b0;
        end else begin
            req = "R7";
        end
        @(negedge clk);
        chk(bit_out,   mbit, req, "bit at decision edge");
        chk(bit_valid, mvld, req, "valid at decision edge");
    endtask

    task automatic send_tone(input int k, input real amp, input int count);
        for (int i = 0; i < count; i++) begin
            send(clamp(int'(amp * $sin(2.0 * PI * real'(k * ph) / 12.0))));
            ph++;
        end
    endtask

    task automatic send_mix(input real a0, input real a1, input int count);
        for (int i = 0; i < count; i++) begin
            send(clamp(int'(a0 * $sin(2.0 * PI * real'(ph) / 12.0) +
                            a1 * $sin(2.0 * PI * real'(2 * ph) / 12.0 + 0.7))));
            ph++;
        end
    endtask

    task automatic send_noise(input int count);
        for (int i = 0; i < count; i++) begin
            lfsr = step_lfsr(lfsr);
            send(int'($signed(lfsr[SW-1:0])));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(bit_out,   1'b1, "R1", "bit after reset");
        chk(bit_valid, 1'b0, "R1", "valid after reset");
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        int hlist[5];
        hlist = '{0, 40, 400, 4000, 65535};
        rst_n = 1'b0;
        smp_vld = 1'b0;
        smp_data = '0;
        hyst = '0;
        @(negedge clk);
        do_reset();

        // Fill boundary with a strong zero tone, then tone changes and noise.
        send_tone(1, 100.0, 11);
        send_tone(1, 100.0, 14);
        send_tone(2, 100.0, 30);
        send_noise(20);

        // Reset mid-run, R1: slots restart at 0; then sweep the margin.
        send_tone(2, 50.0, 5);
        do_reset();
        for (int h = 0; h < 5; h++) begin
            hyst = HW'(hlist[h]);
            send_tone(1, 30.0, 14);
            send_tone(2, 127.0, 14);
            send_tone(1, 200.0, 14);
            send_mix(60.0, 55.0, 14);
            send_tone(2, 10.0, 14);
            send_mix(40.0, 80.0, 14);
            send_noise(16);
        end

        // Full-scale values to exercise accumulator range.
        hyst = '0;
        for (int i = 0; i < 24; i++) send((i % 2) ? -128 : 127);
        for (int i = 0; i < 14; i++) send(-128);
        send_tone(1, 127.0, 14);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule